// File: doc/BRIEF.md
# Two-Wire Command/Data Slave for a Display Driver

This block is the two-wire serial (I2C-style) slave front end of a display controller. It watches a clock line and a bidirectional data line and finds start, repeated-start and stop conditions. It then takes the first byte after each start as an address. The top six address bits must equal a fixed four-bit tag (0111) followed by two board strap inputs. Address bit 1 selects whether the bytes that follow are commands or display RAM data, and address bit 0 selects the transfer direction.

In a write, every byte shifted in MSB first is acknowledged. It leaves the block as a one-cycle strobe: on the command port when the latched select bit is 0, on the RAM write port when it is 1. In a read, bytes come from a RAM read port and are shifted out MSB first. Each byte that is loaded raises a one-cycle advance pulse on that port. The master ends the read by not acknowledging a byte. Both lines pass through a synchroniser into the system clock domain, and all edges are detected there. The data line is driven only as an open-drain pull-down.

Top module: `disp_i2c_slave`

## Requirements
- R1: SDA falling while SCL is high is a start condition. The next eight SCL rising edges shift in an address byte, MSB first.
- R2: SDA rising while SCL is high is a stop condition. It returns the block to idle with SDA released, even in the middle of a byte, and no strobe is raised for the partial byte.
- R3: An address whose bits [7:2] equal {0111, strap_x, strap_y} is acknowledged: sda_pull is 1 through the ninth SCL clock.
- R4: An address that does not match is not acknowledged. After it, no strobe is raised and SDA is never pulled until the next start.
- R5: In a write with address bit 1 = 0, each completed byte raises cmd_stb for exactly one cycle, with the byte on wr_byte.
- R6: In a write with address bit 1 = 1, each completed byte raises ram_wr for exactly one cycle, with the byte on wr_byte.
- R7: Every byte received in a matched write is acknowledged on the ninth clock.
- R8: In a read (address bit 0 = 1), each byte is taken from rd_byte when it is loaded and sent MSB first. ram_rd pulses for one cycle at each load.
- R9: A master not-acknowledge after a read byte ends the read. SDA is released and stays released, and no further byte is loaded.
- R10: A repeated start without a stop begins a new address phase, and the new address alone decides the mode.
- R11: sda_pull changes only while the synchronised SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_x | input | 1 | Address strap, address bit 3 |
| strap_y | input | 1 | Address strap, address bit 2 |
| scl_in | input | 1 | Serial clock line, asynchronous |
| sda_in | input | 1 | Serial data line as seen on the pad, asynchronous |
| sda_pull | output | 1 | 1 pulls the data line low, 0 releases it |
| cmd_stb | output | 1 | One-cycle strobe for a received command byte |
| ram_wr | output | 1 | One-cycle strobe for a received display RAM byte |
| wr_byte | output | BYTE_W | Byte carried by cmd_stb or ram_wr |
| ram_rd | output | 1 | One-cycle pulse when a read byte is taken from rd_byte |
| rd_byte | input | BYTE_W | Display RAM read data, valid before each load |

## Verification
The hardest states to reach are those that end a transfer at an odd point. These are a stop after half a byte, a repeated start straight after a rejected address, and the clocks a master keeps sending after it has not acknowledged a read byte. The bench drives the lines as an open-drain bus from bit-level tasks. This lets it abort a byte after four bits, put a start into a transfer that is being ignored, and clock one more byte after the not-acknowledge to show that SDA stays high. Pulls on SDA while SCL is high are counted throughout the whole run.

// File: rtl/i2cd_pkg.sv
package i2cd_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_AACK,
      ST_WBYTE,
      ST_WACK,
      ST_RBYTE,
      ST_RACK
   } i2cd_state_e;

   localparam int unsigned STRAP_BITS = 2;
   localparam int unsigned CTRL_BITS  = 2;
endpackage

// File: rtl/i2cd_line_sync.sv
module i2cd_line_sync #(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_in,
   input  logic sda_in,
   output logic scl_lvl,
   output logic sda_lvl,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_evt,
   output logic stop_evt
);
   localparam int unsigned TOP = SYNC_STAGES - 1;

   if (SYNC_STAGES < 2) begin : g_bad_stages
      $error("i2cd_line_sync: SYNC_STAGES must be at least 2");
   end

   logic [TOP:0] scl_chain, sda_chain;
   logic         scl_q, sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_chain <= '1;
         sda_chain <= '1;
         scl_q     <= 1'b1;
         sda_q     <= 1'b1;
      end else begin
         scl_chain <= {scl_chain[TOP-1:0], scl_in};
         sda_chain <= {sda_chain[TOP-1:0], sda_in};
         scl_q     <= scl_chain[TOP];
         sda_q     <= sda_chain[TOP];
      end
   end

   assign scl_lvl   = scl_chain[TOP];
   assign sda_lvl   = sda_chain[TOP];
   assign scl_rise  = scl_lvl & ~scl_q;
   assign scl_fall  = ~scl_lvl & scl_q;
   assign start_evt = scl_lvl & scl_q & sda_q & ~sda_lvl;
   assign stop_evt  = scl_lvl & scl_q & ~sda_q & sda_lvl;

   // R1
   start_stop_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_evt |=> !stop_evt);
endmodule

// File: rtl/i2cd_xfer_ctrl.sv
module i2cd_xfer_ctrl
   import i2cd_pkg::*;
#(
   parameter int unsigned        BYTE_W     = 8,
   parameter int unsigned        ADDR_TAG_W = 4,
   parameter logic [ADDR_TAG_W-1:0] ADDR_TAG = 4'b0111
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              strap_x,
   input  logic              strap_y,
   input  logic              scl_lvl,
   input  logic              sda_lvl,
   input  logic              scl_rise,
   input  logic              scl_fall,
   input  logic              start_evt,
   input  logic              stop_evt,
   input  logic [BYTE_W-1:0] rd_byte,
   output logic              sda_pull,
   output logic              cmd_stb,
   output logic              ram_wr,
   output logic [BYTE_W-1:0] wr_byte,
   output logic              ram_rd
);
   localparam int unsigned CNT_W = $clog2(BYTE_W + 1);
   localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

   if (ADDR_TAG_W + STRAP_BITS + CTRL_BITS != BYTE_W) begin : g_bad_layout
      $error("i2cd_xfer_ctrl: tag, strap and control bits must fill one byte");
   end

   i2cd_state_e       cur;
   logic [CNT_W-1:0]  cnt;
   logic [BYTE_W-1:0] shreg;
   logic              dc_q, rw_q, mack;
   logic              addr_hit;

   assign addr_hit = (shreg[BYTE_W-1:CTRL_BITS] == {ADDR_TAG, strap_x, strap_y});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur      <= ST_IDLE;
         cnt      <= '0;
         shreg    <= '0;
         dc_q     <= 1'b0;
         rw_q     <= 1'b0;
         mack     <= 1'b0;
         sda_pull <= 1'b0;
         cmd_stb  <= 1'b0;
         ram_wr   <= 1'b0;
         ram_rd   <= 1'b0;
         wr_byte  <= '0;
      end else begin
         cmd_stb <= 1'b0;
         ram_wr  <= 1'b0;
         ram_rd  <= 1'b0;
         if (start_evt) begin
            cur      <= ST_ADDR;
            cnt      <= '0;
            sda_pull <= 1'b0;
         end else if (stop_evt) begin
            cur      <= ST_IDLE;
            sda_pull <= 1'b0;
         end else begin
            case (cur)
               ST_ADDR, ST_WBYTE: begin
                  if (scl_rise && cnt != FULL) begin
                     shreg <= {shreg[BYTE_W-2:0], sda_lvl};
                     cnt   <= cnt + 1'b1;
                  end else if (scl_fall && cnt == FULL) begin
                     if (cur == ST_ADDR) begin
                        if (addr_hit) begin
                           sda_pull <= 1'b1;
                           dc_q     <= shreg[1];
                           rw_q     <= shreg[0];
                           cur      <= ST_AACK;
                        end else begin
                           cur <= ST_IDLE;
                        end
                     end else begin
                        sda_pull <= 1'b1;
                        wr_byte  <= shreg;
                        cmd_stb  <= ~dc_q;
                        ram_wr   <= dc_q;
                        cur      <= ST_WACK;
                     end
                  end
               end
               ST_AACK, ST_WACK: begin
                  if (scl_fall) begin
                     cnt <= '0;
                     if (cur == ST_AACK && rw_q) begin
                        shreg    <= rd_byte;
                        ram_rd   <= 1'b1;
                        sda_pull <= ~rd_byte[BYTE_W-1];
                        cur      <= ST_RBYTE;
                     end else begin
                        sda_pull <= 1'b0;
                        cur      <= ST_WBYTE;
                     end
                  end
               end
               ST_RBYTE: begin
                  if (scl_fall) begin
                     if (cnt == LAST) begin
                        sda_pull <= 1'b0;
                        cur      <= ST_RACK;
                     end else begin
                        cnt      <= cnt + 1'b1;
                        shreg    <= shreg << 1;
                        sda_pull <= ~shreg[BYTE_W-2];
                     end
                  end
               end
               ST_RACK: begin
                  if (scl_rise) begin
                     mack <= ~sda_lvl;
                  end else if (scl_fall) begin
                     cnt <= '0;
                     if (mack) begin
                        shreg    <= rd_byte;
                        ram_rd   <= 1'b1;
                        sda_pull <= ~rd_byte[BYTE_W-1];
                        cur      <= ST_RBYTE;
                     end else begin
                        cur <= ST_IDLE;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end

   // R1
   start_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_evt |=> (cur == ST_ADDR));
   // R2
   stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stop_evt |=> !sda_pull);
   // R4
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cur == ST_IDLE) |-> (!sda_pull && !cmd_stb && !ram_wr));
   // R5
   cmd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_stb |=> !cmd_stb);
   // R6
   ram_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ram_wr |=> !ram_wr);
   // R8
   rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ram_rd |=> !ram_rd);
   // R11
   sda_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sda_pull != $past(sda_pull)) |-> !$past(scl_lvl));
endmodule

// File: rtl/disp_i2c_slave.sv
module disp_i2c_slave #(
   parameter int unsigned           SYNC_STAGES = 2,
   parameter int unsigned           BYTE_W      = 8,
   parameter int unsigned           ADDR_TAG_W  = 4,
   parameter logic [ADDR_TAG_W-1:0] ADDR_TAG    = 4'b0111
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              strap_x,
   input  logic              strap_y,
   input  logic              scl_in,
   input  logic              sda_in,
   output logic              sda_pull,
   output logic              cmd_stb,
   output logic              ram_wr,
   output logic [BYTE_W-1:0] wr_byte,
   output logic              ram_rd,
   input  logic [BYTE_W-1:0] rd_byte
);
   logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_evt, stop_evt;

   i2cd_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_in    (scl_in),
      .sda_in    (sda_in),
      .scl_lvl   (scl_lvl),
      .sda_lvl   (sda_lvl),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_evt (start_evt),
      .stop_evt  (stop_evt)
   );

   i2cd_xfer_ctrl #(
      .BYTE_W     (BYTE_W),
      .ADDR_TAG_W (ADDR_TAG_W),
      .ADDR_TAG   (ADDR_TAG)
   ) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .strap_x   (strap_x),
      .strap_y   (strap_y),
      .scl_lvl   (scl_lvl),
      .sda_lvl   (sda_lvl),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_evt (start_evt),
      .stop_evt  (stop_evt),
      .rd_byte   (rd_byte),
      .sda_pull  (sda_pull),
      .cmd_stb   (cmd_stb),
      .ram_wr    (ram_wr),
      .wr_byte   (wr_byte),
      .ram_rd    (ram_rd)
   );
endmodule

// File: tb/disp_i2c_slave_test.sv
module disp_i2c_slave_test;
   localparam int Q = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       scl_m = 1'b1;
   logic       sda_m = 1'b1;
   logic       sda_pull, cmd_stb, ram_wr, ram_rd;
   logic [7:0] wr_byte, rd_byte;
   wire        sda_line = sda_m & ~sda_pull;

   int checks = 0, fails = 0;
   int cmd_n = 0, ram_n = 0, rd_n = 0, r11_bad = 0;
   logic [7:0] cmd_log [32];
   logic [7:0] ram_log [32];
   logic       pull_q = 1'b0;
   bit         done = 1'b0;

   always #5 clk = ~clk;

   disp_i2c_slave uut (
      .clk      (clk),
      .rst_n    (rst_n),
      .strap_x  (1'b1),
      .strap_y  (1'b0),
      .scl_in   (scl_m),
      .sda_in   (sda_line),
      .sda_pull (sda_pull),
      .cmd_stb  (cmd_stb),
      .ram_wr   (ram_wr),
      .wr_byte  (wr_byte),
      .ram_rd   (ram_rd),
      .rd_byte  (rd_byte)
   );

   assign rd_byte = 8'hA0 + rd_n[7:0];

   always @(posedge clk) begin
      if (cmd_stb) begin cmd_log[cmd_n[4:0]] <= wr_byte; cmd_n <= cmd_n + 1; end
      if (ram_wr)  begin ram_log[ram_n[4:0]] <= wr_byte; ram_n <= ram_n + 1; end
      if (ram_rd)  rd_n <= rd_n + 1;
      pull_q <= sda_pull;
      // R11: the pull may only move while the master holds SCL low
      if (rst_n && (sda_pull != pull_q) && scl_m) r11_bad <= r11_bad + 1;
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wq(input int n = 1);
      repeat (n * Q) @(negedge clk);
   endtask

   task automatic m_start;
      sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
   endtask

   task automatic m_stop;
      sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq();
   endtask

   task automatic m_bit(input logic b);
      sda_m = b; wq(); scl_m = 1'b1; wq(2); scl_m = 1'b0; wq();
   endtask

   task automatic m_write(input logic [7:0] b, output bit ack);
      for (int i = 7; i >= 0; i--) m_bit(b[i]);
      sda_m = 1'b1; wq(); scl_m = 1'b1; wq();
      ack = (sda_line == 1'b0);
      wq(); scl_m = 1'b0; wq();
   endtask

   task automatic m_read(input bit give_ack, output logic [7:0] b);
      sda_m = 1'b1;
      for (int i = 7; i >= 0; i--) begin
         wq(); scl_m = 1'b1; wq(); b[i] = sda_line; wq(); scl_m = 1'b0;
      end
      sda_m = give_ack ? 1'b0 : 1'b1;
      wq(); scl_m = 1'b1; wq(2); scl_m = 1'b0; wq();
      sda_m = 1'b1;
   endtask

   // {address, data, expected address ack, kind: 0 none, 1 command, 2 RAM}
   // straps x=1 y=0, so the matching prefix is 011110
   localparam logic [18:0] VEC [7] = '{
      {8'h78, 8'h3C, 1'b1, 2'd1},
      {8'h7A, 8'hC5, 1'b1, 2'd2},
      {8'h70, 8'h55, 1'b0, 2'd0},
      {8'h7C, 8'h81, 1'b0, 2'd0},
      {8'h7A, 8'h00, 1'b1, 2'd2},
      {8'h78, 8'hFF, 1'b1, 2'd1},
      {8'h38, 8'h12, 1'b0, 2'd0}
   };

   initial begin
      bit         ack;
      logic [7:0] a, d, b0, b1, b2;
      logic       ea;
      logic [1:0] k;
      int         c0, r0, p0;

      repeat (4) @(negedge clk);
      chk(sda_pull == 1'b0, "R2 reset pull", int'(sda_pull), 0);
      chk({cmd_stb, ram_wr, ram_rd} == 3'b000, "R2 reset strobes",
          int'({cmd_stb, ram_wr, ram_rd}), 0);
      rst_n = 1'b1;
      wq(2);

      for (int i = 0; i < 7; i++) begin
         {a, d, ea, k} = VEC[i];
         c0 = cmd_n; r0 = ram_n;
         m_start();
         m_write(a, ack);
         chk(ack == ea, "R1 R3 R4 address ack", int'(ack), int'(ea));
         m_write(d, ack);
         chk(ack == ea, ea ? "R7 data ack" : "R4 data ignored", int'(ack), int'(ea));
         m_stop(); wq();
         if (k == 2'd1) begin
            chk(cmd_n == c0 + 1 && ram_n == r0, "R5 command strobe count", cmd_n - c0, 1);
            chk(cmd_log[c0[4:0]] == d, "R5 command byte", int'(cmd_log[c0[4:0]]), int'(d));
         end else if (k == 2'd2) begin
            chk(ram_n == r0 + 1 && cmd_n == c0, "R6 ram strobe count", ram_n - r0, 1);
            chk(ram_log[r0[4:0]] == d, "R6 ram byte", int'(ram_log[r0[4:0]]), int'(d));
         end else begin
            chk(cmd_n == c0 && ram_n == r0, "R4 no strobe", (cmd_n - c0) + (ram_n - r0), 0);
         end
      end

      // R6 R7: burst of RAM bytes
      r0 = ram_n;
      m_start(); m_write(8'h7A, ack);
      m_write(8'h11, ack); chk(ack, "R7 burst ack 1", int'(ack), 1);
      m_write(8'h22, ack); chk(ack, "R7 burst ack 2", int'(ack), 1);
      m_write(8'h33, ack); chk(ack, "R7 burst ack 3", int'(ack), 1);
      m_stop(); wq();
      chk(ram_n == r0 + 3, "R6 burst count", ram_n - r0, 3);
      chk({ram_log[r0[4:0]], ram_log[(r0 + 1) & 31], ram_log[(r0 + 2) & 31]} == 24'h112233,
          "R6 burst order", int'({ram_log[r0[4:0]], ram_log[(r0 + 1) & 31], ram_log[(r0 + 2) & 31]}),
          24'h112233);

      // R8 R9: two-byte read, then not-acknowledge
      p0 = rd_n;
      m_start(); m_write(8'h7B, ack);
      chk(ack, "R3 read address ack", int'(ack), 1);
      m_read(1'b1, b0);
      m_read(1'b0, b1);
      chk(b0 == 8'(8'hA0 + p0), "R8 first read byte", int'(b0), int'(8'(8'hA0 + p0)));
      chk(b1 == 8'(8'hA0 + p0 + 1), "R8 second read byte", int'(b1), int'(8'(8'hA0 + p0 + 1)));
      chk(sda_pull == 1'b0, "R9 released after nack", int'(sda_pull), 0);
      m_read(1'b0, b2);
      chk(b2 == 8'hFF, "R9 no drive after nack", int'(b2), 8'hFF);
      chk(rd_n == p0 + 2, "R8 one pop per byte", rd_n - p0, 2);
      m_stop(); wq();

      // R10: repeated start switches command to RAM mode
      c0 = cmd_n; r0 = ram_n;
      m_start(); m_write(8'h78, ack); m_write(8'h5A, ack);
      m_start(); m_write(8'h7A, ack);
      chk(ack, "R10 second address ack", int'(ack), 1);
      m_write(8'h6B, ack); m_stop(); wq();
      chk(cmd_n == c0 + 1 && cmd_log[c0[4:0]] == 8'h5A, "R10 command before restart",
          int'(cmd_log[c0[4:0]]), 8'h5A);
      chk(ram_n == r0 + 1 && ram_log[r0[4:0]] == 8'h6B, "R10 ram after restart",
          int'(ram_log[r0[4:0]]), 8'h6B);

      // R4 R10: restart rescues a rejected transfer
      c0 = cmd_n;
      m_start(); m_write(8'h70, ack);
      chk(!ack, "R4 rejected address", int'(ack), 0);
      m_write(8'h99, ack);
      m_start(); m_write(8'h78, ack); m_write(8'h42, ack); m_stop(); wq();
      chk(cmd_n == c0 + 1 && cmd_log[c0[4:0]] == 8'h42, "R10 restart after reject",
          int'(cmd_log[c0[4:0]]), 8'h42);

      // R2: stop after half a byte
      c0 = cmd_n;
      m_start(); m_write(8'h78, ack);
      m_bit(1'b1); m_bit(1'b0); m_bit(1'b1); m_bit(1'b1);
      m_stop(); wq();
      chk(cmd_n == c0, "R2 partial byte dropped", cmd_n - c0, 0);
      chk(sda_pull == 1'b0, "R2 released after stop", int'(sda_pull), 0);
      m_start(); m_write(8'h78, ack); m_write(8'hC3, ack); m_stop(); wq();
      chk(cmd_n == c0 + 1 && cmd_log[c0[4:0]] == 8'hC3, "R2 next transfer after stop",
          int'(cmd_log[c0[4:0]]), 8'hC3);

      chk(r11_bad == 0, "R11 pull moved with SCL high", r11_bad, 0);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   end
endmodule